// File: doc/BRIEF.md
# Two-Thread Front-End Grant Arbiter

This block makes the per-cycle control decisions for a front end shared by two hardware threads. Each clock it picks at most one thread to fetch and at most one thread to decode, so a whole dispatch group always belongs to one thread. It also raises a per-thread partial-flush request. The choice is steered by four things: a software priority level per thread, the number of reorder-buffer groups each thread holds, outstanding second-level cache misses, and long-latency operations.

Reorder-buffer use is modelled only as counts. Every group a thread allocates is reported on an increment pin and every group it retires on a decrement pin, and the block keeps a saturating count for each thread. A programmable threshold marks a thread as a heavy user. A heavy thread loses fetch to a light one. Decode is withheld from a thread while it has cache misses pending, and from the moment it reports a long-latency operation until that operation completes. Between two threads that are both eligible and otherwise equal, the software levels share out the slots through a weighted slot counter.

All outputs are registered. A grant shown in cycle n+1 reflects the inputs and the state of cycle n.

Top module: `smt_front_arb`

## Requirements
- R1: While reset is high, and in the cycle after it, all of fetch_gnt, decode_gnt and flush_req are 0. After reset the occupancy threshold is 12 groups and both occupancy counts are 0.
- R2: At most one bit of fetch_gnt and at most one bit of decode_gnt is set in any cycle.
- R3: A thread whose 3-bit level (sw_prio bits [2:0] for thread 0, [5:3] for thread 1) is 0 never receives a grant. When only one thread is eligible, it receives the grant every cycle.
- R4: When both threads are eligible, at equal level and with equal occupancy status, the grants alternate. After reset the first such grant goes to thread 0.
- R5: When both threads are eligible with levels that differ by d > 0, the grant pattern repeats every 2^(d+1) contended cycles. The lower-level thread wins exactly one slot in each period, and that slot is the first contended cycle after reset. The higher-level thread wins the rest.
- R6: rob_alloc[t] adds one group to thread t's count and rob_retire[t] removes one. The count saturates at 0 and at 20. When both threads are fetch-eligible and exactly one has a count strictly above the threshold, fetch goes to the other thread. A count equal to the threshold is not above it. Decode is not affected by the counts.
- R7: A cycle with occ_thr_we high loads occ_thr_val into the threshold, and the next cycle's arbitration uses the new value.
- R8: While l2_miss[t] is high, thread t is given no decode grant in the next cycle. Its fetch grants are unaffected.
- R9: A pulse on lld_event[t] gives a one-cycle flush_req[t] in the next cycle. Thread t gets no decode grant from the cycle of the event onward. It becomes eligible again in the cycle that lld_done[t] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_prio | input | 2*PRIO_W | Software level per thread, thread t at bits t*PRIO_W |
| rob_alloc | input | 2 | Per-thread one-group allocation strobe |
| rob_retire | input | 2 | Per-thread one-group retirement strobe |
| occ_thr_we | input | 1 | Load strobe for the occupancy threshold |
| occ_thr_val | input | OCC_W | New occupancy threshold |
| l2_miss | input | 2 | Per-thread outstanding-miss level |
| lld_event | input | 2 | Per-thread long-latency operation strobe |
| lld_done | input | 2 | Per-thread completion strobe for that operation |
| fetch_gnt | output | 2 | Registered fetch grant, one bit per thread |
| decode_gnt | output | 2 | Registered decode grant, one bit per thread |
| flush_req | output | 2 | Registered one-cycle partial-flush request |

## Verification
The assertions check the properties that hold on every cycle. These are:
- that grants are mutually exclusive;
- that an idle thread is never granted;
- that a thread alone gets every fetch grant;
- that a pending miss or a long-latency event withholds the next decode grant;
- that the flush pulse follows the event exactly.

Some behaviours depend on history, and only the bench scenarios show them:
- the grant shares set by the weighted slot counter across all level pairs;
- the alternation for tied levels;
- the threshold boundary and counter saturation;
- reprogramming the threshold;
- the release of a decode stall on completion.

// File: rtl/smt_arb_pkg.sv
package smt_arb_pkg;
  localparam int NTHR = 2;
  typedef logic [NTHR-1:0] thr_vec_t;

  function automatic thr_vec_t pick_one(input logic sel_t1);
    return sel_t1 ? thr_vec_t'(2'b10) : thr_vec_t'(2'b01);
  endfunction
endpackage

// File: rtl/smt_rob_occ.sv
module smt_rob_occ
  import smt_arb_pkg::*;
#(
  parameter int GRP_MAX = 20,
  parameter int THR_RST = 12,
  parameter int OCC_W   = $clog2(GRP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  thr_vec_t         inc,
  input  thr_vec_t         dec,
  input  logic             thr_we,
  input  logic [OCC_W-1:0] thr_val,
  output thr_vec_t         heavy
);
  logic [OCC_W-1:0] thr_q;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= OCC_W'(THR_RST);
    else if (thr_we) thr_q <= thr_val;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic [OCC_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q <= '0;
      end else begin
        case ({inc[t], dec[t]})
          2'b10: if (cnt_q < OCC_W'(GRP_MAX)) cnt_q <= cnt_q + 1'b1;
          2'b01: if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          default: cnt_q <= cnt_q;
        endcase
      end
    end
    assign heavy[t] = cnt_q > thr_q;
  end
endmodule

// File: rtl/smt_lld_gate.sv
module smt_lld_gate
  import smt_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  thr_vec_t ev,
  input  thr_vec_t done,
  output thr_vec_t stall,
  output thr_vec_t flush_q
);
  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    logic blk_q;
    logic blk_d;
    assign blk_d    = ev[t] | (blk_q & ~done[t]);
    assign stall[t] = blk_d;
    always_ff @(posedge clk) begin
      if (rst) begin
        blk_q      <= 1'b0;
        flush_q[t] <= 1'b0;
      end else begin
        blk_q      <= blk_d;
        flush_q[t] <= ev[t];
      end
    end
  end
endmodule

// File: rtl/smt_slot_pick.sv
module smt_slot_pick
  import smt_arb_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  thr_vec_t          elig,
  input  thr_vec_t          demote,
  input  logic [PRIO_W-1:0] prio_a,
  input  logic [PRIO_W-1:0] prio_b,
  output thr_vec_t          gnt_q
);
  localparam int CNT_W = 2 ** PRIO_W;

  logic [CNT_W-1:0]  slot_q;
  logic [CNT_W-1:0]  mask;
  logic [PRIO_W-1:0] diff;
  logic              rr_q;
  logic              a_high;
  logic              tie_use;
  logic              wgt_use;
  thr_vec_t          gnt_d;

  always_comb begin
    a_high  = prio_a > prio_b;
    diff    = a_high ? prio_a - prio_b : prio_b - prio_a;
    mask    = {CNT_W{1'b1}} >> (CNT_W - 1 - int'(diff));
    gnt_d   = '0;
    tie_use = 1'b0;
    wgt_use = 1'b0;
    if (elig != 2'b11) begin
      gnt_d = elig;
    end else if (demote[0] != demote[1]) begin
      gnt_d = pick_one(demote[0]);
    end else if (diff == '0) begin
      tie_use = 1'b1;
      gnt_d   = pick_one(rr_q);
    end else begin
      wgt_use = 1'b1;
      if ((slot_q & mask) == '0) gnt_d = pick_one(a_high);
      else                       gnt_d = pick_one(!a_high);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q  <= '0;
      slot_q <= '0;
      rr_q   <= 1'b0;
    end else begin
      gnt_q <= gnt_d;
      if (tie_use) rr_q   <= ~rr_q;
      if (wgt_use) slot_q <= slot_q + 1'b1;
    end
  end
endmodule

// File: rtl/smt_front_arb.sv
module smt_front_arb
  import smt_arb_pkg::*;
#(
  parameter int PRIO_W      = 3,
  parameter int ROB_GROUPS  = 20,
  parameter int OCC_THR_RST = 12,
  localparam int OCC_W      = $clog2(ROB_GROUPS + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*PRIO_W-1:0]    sw_prio,
  input  logic [1:0]             rob_alloc,
  input  logic [1:0]             rob_retire,
  input  logic                   occ_thr_we,
  input  logic [OCC_W-1:0]       occ_thr_val,
  input  logic [1:0]             l2_miss,
  input  logic [1:0]             lld_event,
  input  logic [1:0]             lld_done,
  output logic [1:0]             fetch_gnt,
  output logic [1:0]             decode_gnt,
  output logic [1:0]             flush_req
);
  logic [PRIO_W-1:0] lvl0;
  logic [PRIO_W-1:0] lvl1;
  thr_vec_t runnable;
  thr_vec_t heavy;
  thr_vec_t stall;
  thr_vec_t dec_elig;

  assign lvl0     = sw_prio[PRIO_W-1:0];
  assign lvl1     = sw_prio[2*PRIO_W-1:PRIO_W];
  assign runnable = {lvl1 != '0, lvl0 != '0};
  assign dec_elig = runnable & ~l2_miss & ~stall;

  smt_rob_occ #(.GRP_MAX(ROB_GROUPS), .THR_RST(OCC_THR_RST), .OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst(rst), .inc(rob_alloc), .dec(rob_retire),
    .thr_we(occ_thr_we), .thr_val(occ_thr_val), .heavy(heavy)
  );

  smt_lld_gate u_lld (
    .clk(clk), .rst(rst), .ev(lld_event), .done(lld_done),
    .stall(stall), .flush_q(flush_req)
  );

  smt_slot_pick #(.PRIO_W(PRIO_W)) u_fetch (
    .clk(clk), .rst(rst), .elig(runnable), .demote(heavy),
    .prio_a(lvl0), .prio_b(lvl1), .gnt_q(fetch_gnt)
  );

  smt_slot_pick #(.PRIO_W(PRIO_W)) u_decode (
    .clk(clk), .rst(rst), .elig(dec_elig), .demote(2'b00),
    .prio_a(lvl0), .prio_b(lvl1), .gnt_q(decode_gnt)
  );
endmodule

// File: rtl/smt_front_arb_chk.sv
module smt_front_arb_chk #(
  parameter int PRIO_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [2*PRIO_W-1:0] sw_prio,
  input logic [1:0]          l2_miss,
  input logic [1:0]          lld_event,
  input logic [1:0]          fetch_gnt,
  input logic [1:0]          decode_gnt,
  input logic [1:0]          flush_req
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (fetch_gnt == 2'b00 && decode_gnt == 2'b00 && flush_req == 2'b00));

  a_r2_fetch_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fetch_gnt));

  a_r2_decode_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(decode_gnt));

  for (genvar t = 0; t < 2; t++) begin : g_thr
    a_r3_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
      (sw_prio[t*PRIO_W +: PRIO_W] == '0) |=> (!fetch_gnt[t] && !decode_gnt[t]));

    a_r3_sole_fetch: assert property (@(posedge clk) disable iff (rst)
      (sw_prio[t*PRIO_W +: PRIO_W] != '0 && sw_prio[(1-t)*PRIO_W +: PRIO_W] == '0)
        |=> fetch_gnt[t]);

    a_r8_miss_blocks_decode: assert property (@(posedge clk) disable iff (rst)
      l2_miss[t] |=> !decode_gnt[t]);

    a_r9_flush_follows: assert property (@(posedge clk) disable iff (rst)
      lld_event[t] |=> flush_req[t]);

    a_r9_flush_single: assert property (@(posedge clk) disable iff (rst)
      !lld_event[t] |=> !flush_req[t]);

    a_r9_event_stalls: assert property (@(posedge clk) disable iff (rst)
      lld_event[t] |=> !decode_gnt[t]);
  end
endmodule

bind smt_front_arb smt_front_arb_chk #(.PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst(rst), .sw_prio(sw_prio), .l2_miss(l2_miss),
  .lld_event(lld_event), .fetch_gnt(fetch_gnt), .decode_gnt(decode_gnt),
  .flush_req(flush_req)
);

// File: tb/sim_smt_front_arb.sv
module sim_smt_front_arb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 3;
  localparam int OW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2*PW-1:0] sw_prio = '0;
  logic [1:0]    rob_alloc = '0, rob_retire = '0;
  logic          occ_thr_we = 1'b0;
  logic [OW-1:0] occ_thr_val = '0;
  logic [1:0]    l2_miss = '0, lld_event = '0, lld_done = '0;
  logic [1:0]    fetch_gnt, decode_gnt, flush_req;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_front_arb u0 (
    .clk(clk), .rst(rst), .sw_prio(sw_prio), .rob_alloc(rob_alloc),
    .rob_retire(rob_retire), .occ_thr_we(occ_thr_we), .occ_thr_val(occ_thr_val),
    .l2_miss(l2_miss), .lld_event(lld_event), .lld_done(lld_done),
    .fetch_gnt(fetch_gnt), .decode_gnt(decode_gnt), .flush_req(flush_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart(input int p0, input int p1);
    @(negedge clk);
    rst = 1'b1;
    rob_alloc = '0; rob_retire = '0; occ_thr_we = 1'b0;
    l2_miss = '0; lld_event = '0; lld_done = '0;
    sw_prio = {PW'(p1), PW'(p0)};
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Count grants over w cycles; returns counts per thread.
  task automatic window(input int w, output int f0, output int f1,
                        output int d0, output int d1);
    f0 = 0; f1 = 0; d0 = 0; d1 = 0;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      f0 += int'(fetch_gnt[0]); f1 += int'(fetch_gnt[1]);
      d0 += int'(decode_gnt[0]); d1 += int'(decode_gnt[1]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int f0, f1, d0, d1;
    // R1: outputs clear during reset
    repeat (2) @(negedge clk);
    chk("R1 fetch in reset", int'(fetch_gnt), 0);
    chk("R1 decode in reset", int'(decode_gnt), 0);
    chk("R1 flush in reset", int'(flush_req), 0);

    // R3 R4 R5: sweep all level pairs
    for (int p0 = 0; p0 < 8; p0++) begin
      for (int p1 = 0; p1 < 8; p1++) begin
        int w, e0, e1, first;
        restart(p0, p1);
        if (p0 == 0 || p1 == 0 || p0 == p1) begin
          w = 4;
          e0 = (p0 == 0) ? 0 : (p1 == 0) ? 4 : 2;
          e1 = (p1 == 0) ? 0 : (p0 == 0) ? 4 : 2;
          first = (p0 == 0 && p1 == 0) ? 0 : (p0 == 0) ? 2 : 1;
        end else begin
          int d;
          d = (p0 > p1) ? p0 - p1 : p1 - p0;
          w = 1 << (d + 1);
          e0 = (p0 < p1) ? 1 : w - 1;
          e1 = (p1 < p0) ? 1 : w - 1;
          first = (p0 < p1) ? 1 : 2;
        end
        @(negedge clk);
        chk("R4 R5 first fetch grant", int'(fetch_gnt), first);
        chk("R4 R5 first decode grant", int'(decode_gnt), first);
        f0 = int'(fetch_gnt[0]); f1 = int'(fetch_gnt[1]);
        d0 = int'(decode_gnt[0]); d1 = int'(decode_gnt[1]);
        begin
          int g0, g1, h0, h1;
          window(w - 1, g0, g1, h0, h1);
          f0 += g0; f1 += g1; d0 += h0; d1 += h1;
        end
        chk("R3 R5 fetch share t0", f0, e0);
        chk("R3 R5 fetch share t1", f1, e1);
        chk("R3 R5 decode share t0", d0, e0);
        chk("R3 R5 decode share t1", d1, e1);
      end
    end

    // R6: occupancy demotion with default threshold 12 (R1)
    restart(4, 4);
    rob_alloc = 2'b01;
    repeat (13) @(negedge clk);
    rob_alloc = 2'b00;
    @(negedge clk);
    window(4, f0, f1, d0, d1);
    chk("R6 heavy thread loses fetch t0", f0, 0);
    chk("R6 light thread fetch t1", f1, 4);
    chk("R6 decode unaffected t0", d0, 2);
    rob_retire = 2'b01;
    @(negedge clk);
    rob_retire = 2'b00;
    @(negedge clk);
    window(4, f0, f1, d0, d1);
    chk("R6 count at threshold not demoted t0", f0, 2);
    chk("R6 count at threshold not demoted t1", f1, 2);

    // R7: lower the threshold to 8
    occ_thr_we = 1'b1; occ_thr_val = OW'(8);
    @(negedge clk);
    occ_thr_we = 1'b0;
    @(negedge clk);
    window(4, f0, f1, d0, d1);
    chk("R7 new threshold demotes t0", f0, 0);
    chk("R7 new threshold t1", f1, 4);

    // R6: saturation at 20
    rob_alloc = 2'b01;
    repeat (30) @(negedge clk);
    rob_alloc = 2'b00;
    occ_thr_we = 1'b1; occ_thr_val = OW'(19);
    @(negedge clk);
    occ_thr_we = 1'b0;
    rob_retire = 2'b01;
    @(negedge clk);
    rob_retire = 2'b00;
    @(negedge clk);
    window(4, f0, f1, d0, d1);
    chk("R6 saturated count t0", f0, 2);
    chk("R6 saturated count t1", f1, 2);

    // R8: pending miss on thread 0
    l2_miss = 2'b01;
    @(negedge clk);
    window(4, f0, f1, d0, d1);
    chk("R8 decode withheld t0", d0, 0);
    chk("R8 decode to t1", d1, 4);
    chk("R8 fetch unaffected t0", f0, 2);
    l2_miss = 2'b00;
    @(negedge clk);
    window(2, f0, f1, d0, d1);
    chk("R8 decode resumes t0", d0, 1);

    // R9: long-latency event on thread 1
    lld_event = 2'b10;
    @(negedge clk);
    lld_event = 2'b00;
    chk("R9 flush pulse", int'(flush_req), 2);
    chk("R9 decode stalled at event", int'(decode_gnt[1]), 0);
    @(negedge clk);
    chk("R9 flush single cycle", int'(flush_req), 0);
    window(4, f0, f1, d0, d1);
    chk("R9 decode held t1", d1, 0);
    chk("R9 decode to t0", d0, 4);
    lld_done = 2'b10;
    @(negedge clk);
    lld_done = 2'b00;
    d1 = int'(decode_gnt[1]);
    @(negedge clk);
    d1 += int'(decode_gnt[1]);
    chk("R9 decode released t1", d1, 1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule